// File: doc/BRIEF.md
# Cartridge Bus DMA Engine

This block moves bytes between a cartridge-side address space and main memory. Software hands it one command: a main-memory address, a 32-bit cartridge address, a length, and a direction. The engine validates the main-memory range, then decides where the cartridge address points. It may hit a small save-memory window, a large read-only ROM window, or nothing at all. Bytes then move one at a time through three simple synchronous memory ports. Each port uses a request/valid handshake, so the engine waits whenever a memory inserts wait states.

ROM traffic is stored with the byte lanes of every 32-bit word reversed. Bytes beyond the end of the ROM image come back as zeros. The first ROM transfer after reset also stores the main-memory size as a word at a boot-information location. Every command ends the same way, whether it succeeded, failed its range check, or hit unmapped space: the busy flag drops and an interrupt request is latched until software acknowledges it.

Top module: `cart_dma`

## Requirements
- R1: A command moves exactly `startLen + 1` bytes. Main-memory bytes outside the destination range keep their contents.
- R2: If `startMainAddr + startLen + 1 > mainSize`, no port issues a request and the command completes. A sum equal to `mainSize` is still accepted.
- R3: Cartridge addresses from 0x08000000 to 0x08010000 inclusive select save memory in both directions. The save offset is the cartridge address minus 0x08000000, and no lane swap is applied.
- R4: Cartridge addresses from 0x10000000 to 0x1FBFFFFF inclusive select ROM when the direction is toward main memory. Byte i is read from ROM offset `(cart - 0x10000000 + i) ^ 3` and written to main address `(startMainAddr + i) ^ 3`.
- R5: During a ROM transfer, a byte whose unswapped ROM offset is at or beyond `romSize` is not fetched. A zero is written in its place.
- R6: These commands complete without any port request:
  - a cartridge address outside both windows;
  - a ROM-window command toward the cartridge.
- R7: Every completion lowers `busy` and sets `irq` in the same cycle. `irq` then stays high until `irqAck` is pulsed.
- R8: The first ROM transfer after reset that passes the range check writes `mainSize` as four bytes at main offset 0x318, least significant byte at the lowest address. When `bootAlt` is 1, the offset is 0x3F0 instead. Later ROM transfers do not repeat this write.
- R9: `busy` rises in the cycle after an accepted start. A start pulsed while `busy` is high is ignored.
- R10: A request that has not yet seen its valid is held, with address, write enable and write data unchanged, until valid arrives. At most one port requests at a time.
- R11: After reset, `busy` and `irq` are low and no port is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Start pulse for a command |
| startToMain | input | 1 | 1: cartridge to main memory, 0: main memory to cartridge |
| startMainAddr | input | MAIN_AW | Main-memory start byte address |
| startCartAddr | input | CART_AW | Cartridge start byte address |
| startLen | input | LEN_W | Byte count minus one |
| mainSize | input | MAIN_AW | Configured main-memory size in bytes |
| romSize | input | CART_AW | Configured ROM image size in bytes |
| bootAlt | input | 1 | Selects the alternate boot-information offset |
| irqAck | input | 1 | Clears the interrupt request |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Completion interrupt request |
| memReq | output | 1 | Main-memory request |
| memWe | output | 1 | Main-memory write enable |
| memAddr | output | MAIN_AW | Main-memory byte address |
| memWdata | output | 8 | Main-memory write byte |
| memRdata | input | 8 | Main-memory read byte |
| memValid | input | 1 | Main-memory access accepted / data valid |
| romReq | output | 1 | ROM read request |
| romAddr | output | ROM_AW | ROM byte offset |
| romRdata | input | 8 | ROM read byte |
| romValid | input | 1 | ROM data valid |
| saveReq | output | 1 | Save-memory request |
| saveWe | output | 1 | Save-memory write enable |
| saveAddr | output | SAVE_AW | Save-memory byte offset |
| saveWdata | output | 8 | Save-memory write byte |
| saveRdata | input | 8 | Save-memory read byte |
| saveValid | input | 1 | Save-memory access accepted / data valid |

## Verification
The handshake properties assume two things about the memories. First, each memory answers a request only through its own valid line. Second, read data is meaningful in the cycle valid is high. The bench models all three memories that way, inserting pseudo-random wait states from a free-running shift register.

The properties also assume `mainSize` and `romSize` stay constant during a command. The bench changes neither after reset. It pulses `startValid` for one cycle at a time, and the one deliberate overlap is a start issued while `busy` is high, which checks R9.

// File: rtl/cart_dma_pkg.sv
package cart_dma_pkg;

  parameter logic [31:0] SAVE_FIRST = 32'h0800_0000;
  parameter logic [31:0] SAVE_LAST  = 32'h0801_0000;
  parameter logic [31:0] ROM_FIRST  = 32'h1000_0000;
  parameter logic [31:0] ROM_LAST   = 32'h1FBF_FFFF;
  parameter logic [31:0] BOOT_STD   = 32'h0000_0318;
  parameter logic [31:0] BOOT_ALT   = 32'h0000_03F0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_STORE, ST_BOOT, ST_DONE
  } stateT;

  typedef enum logic [1:0] {
    RT_NONE, RT_SAVE, RT_ROM
  } routeT;

  typedef struct packed {
    logic load;
    logic capture;
    logic advance;
    logic bootStep;
    logic selBoot;
  } ctrlStrobeT;

endpackage

// File: rtl/cart_dma_ctrl.sv
module cart_dma_ctrl
  import cart_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       irqAck,
  input  routeT      route,
  input  logic       rangeBad,
  input  logic       lastByte,
  input  logic       pastRomEnd,
  input  logic       needBoot,
  input  logic       bootLast,
  input  logic       toMain,
  input  logic       memValid,
  input  logic       romValid,
  input  logic       saveValid,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       irq,
  output logic       memReq,
  output logic       memWe,
  output logic       romReq,
  output logic       saveReq,
  output logic       saveWe
);

  stateT state, nextState;
  logic  fetchOk, storeOk;

  always_comb begin
    nextState = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    romReq    = 1'b0;
    saveReq   = 1'b0;
    saveWe    = 1'b0;
    fetchOk   = 1'b0;
    storeOk   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startValid) begin
          strobe.load = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        nextState = (rangeBad || route == RT_NONE) ? ST_DONE : ST_FETCH;
      end
      ST_FETCH: begin
        if (!toMain) begin
          memReq  = 1'b1;
          fetchOk = memValid;
        end else if (route == RT_SAVE) begin
          saveReq = 1'b1;
          fetchOk = saveValid;
        end else if (pastRomEnd) begin
          fetchOk = 1'b1;
        end else begin
          romReq  = 1'b1;
          fetchOk = romValid;
        end
        if (fetchOk) begin
          strobe.capture = 1'b1;
          nextState      = ST_STORE;
        end
      end
      ST_STORE: begin
        if (toMain) begin
          memReq  = 1'b1;
          memWe   = 1'b1;
          storeOk = memValid;
        end else begin
          saveReq = 1'b1;
          saveWe  = 1'b1;
          storeOk = saveValid;
        end
        if (storeOk) begin
          if (lastByte) begin
            nextState = (route == RT_ROM && needBoot) ? ST_BOOT : ST_DONE;
          end else begin
            strobe.advance = 1'b1;
            nextState      = ST_FETCH;
          end
        end
      end
      ST_BOOT: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.selBoot = 1'b1;
        if (memValid) begin
          strobe.bootStep = 1'b1;
          if (bootLast) nextState = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_DONE) irq <= 1'b1;
      else if (irqAck)      irq <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/cart_dma_path.sv
module cart_dma_path
  import cart_dma_pkg::*;
#(
  parameter int MAIN_AW = 32,
  parameter int CART_AW = 32,
  parameter int ROM_AW  = 28,
  parameter int SAVE_AW = 17,
  parameter int LEN_W   = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic               startToMain,
  input  logic [MAIN_AW-1:0] startMainAddr,
  input  logic [CART_AW-1:0] startCartAddr,
  input  logic [LEN_W-1:0]   startLen,
  input  logic [MAIN_AW-1:0] mainSize,
  input  logic [CART_AW-1:0] romSize,
  input  logic               bootAlt,
  input  logic [7:0]         memRdata,
  input  logic [7:0]         romRdata,
  input  logic [7:0]         saveRdata,
  output routeT              route,
  output logic               rangeBad,
  output logic               lastByte,
  output logic               pastRomEnd,
  output logic               needBoot,
  output logic               bootLast,
  output logic               toMain,
  output logic [MAIN_AW-1:0] memAddr,
  output logic [7:0]         memWdata,
  output logic [ROM_AW-1:0]  romAddr,
  output logic [SAVE_AW-1:0] saveAddr,
  output logic [7:0]         saveWdata
);

  localparam int SUM_W = ((MAIN_AW > LEN_W) ? MAIN_AW : LEN_W) + 2;

  logic [MAIN_AW-1:0] mainBase;
  logic [CART_AW-1:0] cartReg;
  logic [LEN_W-1:0]   lenReg;
  logic [LEN_W-1:0]   idx;
  logic [7:0]         byteBuf;
  logic [1:0]         bootIdx;
  logic               bootDone;

  logic [SUM_W-1:0]   endSum;
  logic               inSave, inRom;
  logic [CART_AW-1:0] romOff;
  logic [MAIN_AW-1:0] curMain;
  logic [MAIN_AW-1:0] xferAddr;
  logic [MAIN_AW-1:0] bootAddr;
  logic [7:0]         bootByte;
  logic [7:0]         capData;
  logic [31:0]        sizeWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainBase <= '0;
      cartReg  <= '0;
      lenReg   <= '0;
      toMain   <= 1'b0;
      idx      <= '0;
      byteBuf  <= '0;
      bootIdx  <= '0;
      bootDone <= 1'b0;
    end else begin
      if (strobe.load) begin
        mainBase <= startMainAddr;
        cartReg  <= startCartAddr;
        lenReg   <= startLen;
        toMain   <= startToMain;
        idx      <= '0;
      end
      if (strobe.capture) byteBuf <= capData;
      if (strobe.advance) idx <= idx + 1'b1;
      if (strobe.bootStep) begin
        bootIdx <= bootIdx + 1'b1;
        if (bootLast) bootDone <= 1'b1;
      end
    end
  end

  // Command checks and window decode
  assign endSum   = SUM_W'(mainBase) + SUM_W'(lenReg) + SUM_W'(1);
  assign rangeBad = endSum > SUM_W'(mainSize);
  assign inSave   = (cartReg >= CART_AW'(SAVE_FIRST)) && (cartReg <= CART_AW'(SAVE_LAST));
  assign inRom    = (cartReg >= CART_AW'(ROM_FIRST))  && (cartReg <= CART_AW'(ROM_LAST));

  always_comb begin
    route = RT_NONE;
    if (inSave)               route = RT_SAVE;
    else if (inRom && toMain) route = RT_ROM;
  end

  assign lastByte = (idx == lenReg);

  // Address generation
  assign romOff     = cartReg - CART_AW'(ROM_FIRST) + CART_AW'(idx);
  assign pastRomEnd = (romOff >= romSize);
  assign romAddr    = romOff[ROM_AW-1:0] ^ ROM_AW'(3);
  assign saveAddr   = cartReg[SAVE_AW-1:0] - SAVE_FIRST[SAVE_AW-1:0] + SAVE_AW'(idx);
  assign curMain    = mainBase + MAIN_AW'(idx);
  assign xferAddr   = (route == RT_ROM) ? (curMain ^ MAIN_AW'(3)) : curMain;

  // Boot information word
  assign needBoot = !bootDone;
  assign bootLast = (bootIdx == 2'd3);
  assign bootAddr = MAIN_AW'(bootAlt ? BOOT_ALT : BOOT_STD) + MAIN_AW'(bootIdx);
  assign sizeWord = 32'(mainSize);
  always_comb begin
    case (bootIdx)
      2'd0:    bootByte = sizeWord[7:0];
      2'd1:    bootByte = sizeWord[15:8];
      2'd2:    bootByte = sizeWord[23:16];
      default: bootByte = sizeWord[31:24];
    endcase
  end

  // Source byte selection
  always_comb begin
    if (!toMain)                capData = memRdata;
    else if (route == RT_SAVE)  capData = saveRdata;
    else if (pastRomEnd)        capData = 8'h00;
    else                        capData = romRdata;
  end

  assign memAddr   = strobe.selBoot ? bootAddr : xferAddr;
  assign memWdata  = strobe.selBoot ? bootByte : byteBuf;
  assign saveWdata = byteBuf;

endmodule

// File: rtl/cart_dma.sv
module cart_dma
  import cart_dma_pkg::*;
#(
  parameter int MAIN_AW = 32,
  parameter int CART_AW = 32,
  parameter int ROM_AW  = 28,
  parameter int SAVE_AW = 17,
  parameter int LEN_W   = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic               startToMain,
  input  logic [MAIN_AW-1:0] startMainAddr,
  input  logic [CART_AW-1:0] startCartAddr,
  input  logic [LEN_W-1:0]   startLen,
  input  logic [MAIN_AW-1:0] mainSize,
  input  logic [CART_AW-1:0] romSize,
  input  logic               bootAlt,
  input  logic               irqAck,
  output logic               busy,
  output logic               irq,
  output logic               memReq,
  output logic               memWe,
  output logic [MAIN_AW-1:0] memAddr,
  output logic [7:0]         memWdata,
  input  logic [7:0]         memRdata,
  input  logic               memValid,
  output logic               romReq,
  output logic [ROM_AW-1:0]  romAddr,
  input  logic [7:0]         romRdata,
  input  logic               romValid,
  output logic               saveReq,
  output logic               saveWe,
  output logic [SAVE_AW-1:0] saveAddr,
  output logic [7:0]         saveWdata,
  input  logic [7:0]         saveRdata,
  input  logic               saveValid
);

  ctrlStrobeT ctrlStrobe;
  routeT      routeSel;
  logic       rangeBad, lastByte, pastRomEnd, needBoot, bootLast, toMain;

  cart_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .irqAck(irqAck),
    .route(routeSel), .rangeBad(rangeBad), .lastByte(lastByte),
    .pastRomEnd(pastRomEnd), .needBoot(needBoot), .bootLast(bootLast),
    .toMain(toMain), .memValid(memValid), .romValid(romValid),
    .saveValid(saveValid), .strobe(ctrlStrobe), .busy(busy), .irq(irq),
    .memReq(memReq), .memWe(memWe), .romReq(romReq), .saveReq(saveReq),
    .saveWe(saveWe)
  );

  cart_dma_path #(
    .MAIN_AW(MAIN_AW), .CART_AW(CART_AW), .ROM_AW(ROM_AW),
    .SAVE_AW(SAVE_AW), .LEN_W(LEN_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .startToMain(startToMain),
    .startMainAddr(startMainAddr), .startCartAddr(startCartAddr),
    .startLen(startLen), .mainSize(mainSize), .romSize(romSize),
    .bootAlt(bootAlt), .memRdata(memRdata), .romRdata(romRdata),
    .saveRdata(saveRdata), .route(routeSel), .rangeBad(rangeBad),
    .lastByte(lastByte), .pastRomEnd(pastRomEnd), .needBoot(needBoot),
    .bootLast(bootLast), .toMain(toMain), .memAddr(memAddr),
    .memWdata(memWdata), .romAddr(romAddr), .saveAddr(saveAddr),
    .saveWdata(saveWdata)
  );

endmodule

// File: rtl/cart_dma_chk.sv
module cart_dma_chk
  import cart_dma_pkg::*;
#(
  parameter int MAIN_AW = 32,
  parameter int ROM_AW  = 28,
  parameter int SAVE_AW = 17
) (
  input logic               clk,
  input logic               rstN,
  input logic               startValid,
  input logic               irqAck,
  input logic               busy,
  input logic               irq,
  input logic               memReq,
  input logic               memWe,
  input logic [MAIN_AW-1:0] memAddr,
  input logic [7:0]         memWdata,
  input logic               memValid,
  input logic               romReq,
  input logic [ROM_AW-1:0]  romAddr,
  input logic               romValid,
  input logic               saveReq,
  input logic               saveWe,
  input logic [SAVE_AW-1:0] saveAddr,
  input logic [7:0]         saveWdata,
  input logic               saveValid,
  input routeT              routeSel,
  input logic               pastRomEnd,
  input logic               selBoot
);

  a_r11_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!busy && !irq && !memReq && !romReq && !saveReq));

  a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> busy);

  a_r7_irq_at_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);

  a_r7_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> irq);

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  a_r10_rom_hold: assert property (@(posedge clk) disable iff (!rstN)
    (romReq && !romValid) |=> (romReq && $stable(romAddr)));

  a_r10_save_hold: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && !saveValid) |=> (saveReq && $stable(saveAddr) && $stable(saveWe) && $stable(saveWdata)));

  a_r10_one_port: assert property (@(posedge clk) disable iff (!rstN)
    $countones({memReq, romReq, saveReq}) <= 1);

  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !selBoot && routeSel == RT_ROM && pastRomEnd) |-> (memWdata == 8'h00));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !romReq && !saveReq));

endmodule

bind cart_dma cart_dma_chk #(
  .MAIN_AW(MAIN_AW), .ROM_AW(ROM_AW), .SAVE_AW(SAVE_AW)
) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .irqAck(irqAck),
  .busy(busy), .irq(irq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memValid(memValid), .romReq(romReq),
  .romAddr(romAddr), .romValid(romValid), .saveReq(saveReq),
  .saveWe(saveWe), .saveAddr(saveAddr), .saveWdata(saveWdata),
  .saveValid(saveValid), .routeSel(routeSel), .pastRomEnd(pastRomEnd),
  .selBoot(ctrlStrobe.selBoot)
);

// File: tb/cart_dma_tb.sv
module cart_dma_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startToMain = 1'b0;
  logic [31:0] startMainAddr = '0;
  logic [31:0] startCartAddr = '0;
  logic [23:0] startLen = '0;
  logic [31:0] mainSize = 32'd4096;
  logic [31:0] romSize = 32'd256;
  logic        bootAlt = 1'b0;
  logic        irqAck = 1'b0;
  logic        busy, irq;
  logic        memReq, memWe, memValid;
  logic [31:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic        romReq, romValid;
  logic [27:0] romAddr;
  logic [7:0]  romRdata;
  logic        saveReq, saveWe, saveValid;
  logic [16:0] saveAddr;
  logic [7:0]  saveWdata, saveRdata;

  logic [7:0]  mainMem [0:4095];
  logic [7:0]  romMem  [0:1023];
  logic [7:0]  saveMem [0:1023];
  logic [7:0]  lfsr = 8'hA5;
  int          reqCount = 0;
  logic [16:0] lastSaveAddr = '0;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_dma u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startToMain(startToMain),
    .startMainAddr(startMainAddr), .startCartAddr(startCartAddr),
    .startLen(startLen), .mainSize(mainSize), .romSize(romSize),
    .bootAlt(bootAlt), .irqAck(irqAck), .busy(busy), .irq(irq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memValid(memValid), .romReq(romReq),
    .romAddr(romAddr), .romRdata(romRdata), .romValid(romValid),
    .saveReq(saveReq), .saveWe(saveWe), .saveAddr(saveAddr),
    .saveWdata(saveWdata), .saveRdata(saveRdata), .saveValid(saveValid)
  );

  // Memory models with pseudo-random wait states
  assign memValid  = memReq  & ~(lfsr[0] & lfsr[1]);
  assign romValid  = romReq  & ~(lfsr[2] & lfsr[3]);
  assign saveValid = saveReq & ~(lfsr[4] & lfsr[5]);
  assign memRdata  = mainMem[memAddr[11:0]];
  assign romRdata  = romMem[romAddr[9:0]];
  assign saveRdata = saveMem[saveAddr[9:0]];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (memReq || romReq || saveReq) reqCount <= reqCount + 1;
    if (memReq && memWe && memValid) mainMem[memAddr[11:0]] <= memWdata;
    if (saveReq) lastSaveAddr <= saveAddr;
    if (saveReq && saveWe && saveValid) saveMem[saveAddr[9:0]] <= saveWdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkByte(input string req, input int addr, input int exp);
    chk(mainMem[addr] == 8'(exp), req, $sformatf("main[0x%0h]", addr), int'(mainMem[addr]), exp);
  endtask

  task automatic fillMain(input int lo, input int hi, input logic [7:0] v);
    for (int i = lo; i <= hi; i++) mainMem[i] = v;
  endtask

  task automatic runCmd(input bit toMain, input int mainA, input logic [31:0] cartA, input int len);
    @(negedge clk);
    startToMain   = toMain;
    startMainAddr = 32'(mainA);
    startCartAddr = cartA;
    startLen      = 24'(len);
    startValid    = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
    chk(busy == 1'b0 && irq == 1'b1, "R7", "busy/irq at completion", int'({busy, irq}), 1);
  endtask

  task automatic ackIrq();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    chk(irq == 1'b0, "R7", "irq after ack", int'(irq), 0);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && irq == 1'b0, "R11", "busy/irq after reset", int'({busy, irq}), 0);
    chk(!memReq && !romReq && !saveReq, "R11", "requests after reset",
        int'({memReq, romReq, saveReq}), 0);
  endtask

  task automatic testRomBasic();
    fillMain(0, 4095, 8'hEE);
    runCmd(1'b1, 'h100, 32'h1000_0010, 15);
    for (int i = 0; i < 16; i++) chkByte("R4", (('h100 + i) ^ 3), int'(romMem[('h10 + i) ^ 3]));
    chkByte("R1", 'h110, 'hEE);
    chkByte("R1", 'hFF, 'hEE);
    // R8: size 0x1000 stored least significant byte first at 0x318
    chkByte("R8", 'h318, 'h00);
    chkByte("R8", 'h319, 'h10);
    chkByte("R8", 'h31A, 'h00);
    chkByte("R8", 'h31B, 'h00);
    ackIrq();
  endtask

  task automatic testRomTail();
    fillMain('h200, 'h20F, 8'hEE);
    fillMain('h318, 'h31B, 8'h55);
    runCmd(1'b1, 'h200, 32'h1000_00F8, 15);
    for (int i = 0; i < 16; i++) begin
      if ('hF8 + i < 256) chkByte("R5", (('h200 + i) ^ 3), int'(romMem[('hF8 + i) ^ 3]));
      else                chkByte("R5", (('h200 + i) ^ 3), 0);
    end
    chkByte("R8", 'h318, 'h55);
    chkByte("R8", 'h319, 'h55);
    ackIrq();
  endtask

  task automatic testSaveWrite();
    for (int i = 0; i < 10; i++) mainMem['h400 + i] = 8'('hA0 + i);
    runCmd(1'b0, 'h400, 32'h0800_0020, 9);
    for (int i = 0; i < 10; i++)
      chk(saveMem['h20 + i] == 8'('hA0 + i), "R3", "save write byte",
          int'(saveMem['h20 + i]), 'hA0 + i);
    chk(saveMem['h2A] == 8'('h2A * 7 + 'h40), "R1", "save byte past range",
        int'(saveMem['h2A]), 'h2A * 7 + 'h40);
    ackIrq();
  endtask

  task automatic testSaveRead();
    fillMain('h500, 'h50F, 8'hEE);
    runCmd(1'b1, 'h500, 32'h0800_0040, 5);
    for (int i = 0; i < 6; i++) chkByte("R3", 'h500 + i, int'(saveMem['h40 + i]));
    chkByte("R1", 'h506, 'hEE);
    ackIrq();
  endtask

  task automatic testRange();
    fillMain('hFF0, 'hFFF, 8'hEE);
    @(negedge clk);
    reqCount = 0;
    runCmd(1'b1, 'hFF8, 32'h1000_0000, 8);
    chk(reqCount == 0, "R2", "requests on range error", reqCount, 0);
    chkByte("R2", 'hFF8, 'hEE);
    ackIrq();
    runCmd(1'b1, 'hFF8, 32'h1000_0000, 7);
    for (int i = 0; i < 8; i++) chkByte("R2", (('hFF8 + i) ^ 3), int'(romMem[i ^ 3]));
    ackIrq();
  endtask

  task automatic testUnmapped();
    @(negedge clk);
    reqCount = 0;
    runCmd(1'b1, 'h100, 32'h2000_0000, 3);
    chk(reqCount == 0, "R6", "requests, unmapped", reqCount, 0);
    ackIrq();
    runCmd(1'b0, 'h100, 32'h1000_0000, 3);
    chk(reqCount == 0, "R6", "requests, main to ROM", reqCount, 0);
    ackIrq();
    runCmd(1'b1, 'h100, 32'h0801_0001, 0);
    chk(reqCount == 0, "R6", "requests, above save window", reqCount, 0);
    ackIrq();
    runCmd(1'b1, 'h100, 32'h1FC0_0000, 0);
    chk(reqCount == 0, "R6", "requests, above ROM window", reqCount, 0);
    ackIrq();
    // R3: last address of save window still routes to save
    runCmd(1'b0, 'h100, 32'h0801_0000, 0);
    chk(lastSaveAddr == 17'h1_0000, "R3", "save offset at window top", int'(lastSaveAddr), 'h10000);
    ackIrq();
    // R5: last ROM-window address lies past ROM end, zero written
    fillMain('h300, 'h303, 8'hEE);
    runCmd(1'b1, 'h300, 32'h1FBF_FFFF, 0);
    chkByte("R5", 'h303, 0);
    chkByte("R1", 'h300, 'hEE);
    ackIrq();
  endtask

  task automatic testStartWhileBusy();
    fillMain('h600, 'h63F, 8'hEE);
    fillMain('h800, 'h803, 8'hEE);
    @(negedge clk);
    startToMain = 1'b1; startMainAddr = 32'h600; startCartAddr = 32'h1000_0000;
    startLen = 24'd63; startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    repeat (4) @(negedge clk);
    startMainAddr = 32'h800; startCartAddr = 32'h1000_0040; startLen = 24'd3;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9", "no second command", int'(busy), 0);
    chkByte("R9", 'h800, 'hEE);
    for (int i = 0; i < 64; i++) chkByte("R9", (('h600 + i) ^ 3), int'(romMem[i ^ 3]));
    ackIrq();
  endtask

  task automatic testBootAlt();
    bootAlt = 1'b1;
    applyReset();
    fillMain('h3F0, 'h3F3, 8'hEE);
    fillMain('h318, 'h31B, 8'h77);
    runCmd(1'b1, 'h700, 32'h1000_0000, 3);
    chkByte("R8", 'h3F0, 'h00);
    chkByte("R8", 'h3F1, 'h10);
    chkByte("R8", 'h3F2, 'h00);
    chkByte("R8", 'h318, 'h77);
    ackIrq();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      romMem[i]  = 8'(i * 13 + 5);
      saveMem[i] = 8'(i * 7 + 'h40);
    end
    fillMain(0, 4095, 8'hEE);
    applyReset();
    testRomBasic();
    testRomTail();
    testSaveWrite();
    testSaveRead();
    testRange();
    testUnmapped();
    testStartWhileBusy();
    testBootAlt();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule